// File: doc/BRIEF.md
# PC Card Host Register Decoder

This block turns host bus cycles on a PC card serial port into register selects. The host presents an address, a read strobe, a write strobe and a flag that says whether the cycle targets attribute memory or I/O space. A two-bit code picks one of four legacy serial-port base addresses. The block registers its decode and produces one-hot selects for three targets: the card information structure area, the eight card configuration registers and the twelve UART registers. It also produces qualified read and write enables and a per-bit write keep mask.

Several UART registers share an offset. The block resolves each one from the direction of the access and from its own copy of the divisor latch access bit. It captures that bit from writes to the line control offset. The register contents, the serial datapath and the information structure storage sit outside this block. They take the selects and the keep mask produced here.

Top module: `pccard_reg_decode`

## Requirements
- R1: During and right after a synchronous active-high reset, every select output and both enables are 0, `dlab` is 0 and `wr_keep` is all ones.
- R2: An attribute access with address bit 0 at 0 uses the word index `host_addr[9:1]`. Indices below 256 raise `cis_sel` and put the index on `cis_index`. Indices 256 to 263 raise bit (index − 256) of `cfg_sel`. An odd attribute address, or any other index, raises no select, and `cis_index` is then 0.
- R3: An I/O access hits only inside the 8-byte window at the base picked by `com_sel`: 0 picks 0x3F8, 1 picks 0x2F8, 2 picks 0x3E8 and 3 picks 0x2E8. Any other address raises no select. The offset is `host_addr[2:0]`.
- R4: The `uart_sel` bit positions are: 0 receive buffer, 1 transmit holding, 2 divisor low, 3 divisor high, 4 interrupt enable, 5 interrupt identification, 6 FIFO control, 7 line control, 8 modem control, 9 line status, 10 modem status, 11 scratch. At offset 0 with `dlab` 0, a read selects bit 0 and a write selects bit 1.
- R5: With `dlab` at 1, offset 0 selects bit 2 and offset 1 selects bit 3, in both directions. With `dlab` at 0, offset 1 selects bit 4.
- R6: Offset 2 selects bit 5 on reads and bit 6 on writes. Offset 3 selects bit 7 in both directions.
- R7: Offsets 4, 5, 6 and 7 select bits 8, 9, 10 and 11.
- R8: A write that hits offset 3 loads `host_wdata[7]` into `dlab` at that clock edge. The access in that same cycle still decodes with the old value. Reads and other writes leave `dlab` unchanged.
- R9: For a write that selects modem control, `wr_keep` is 0xDF so that bit 5 is not written. For every other cycle it is 0xFF.
- R10: A cycle in which neither strobe is active, or both are, raises no select and no enable. At most one select is ever high.
- R11: All outputs are registered. The decode of a cycle appears after the next rising edge. `sel_rd` or `sel_wr` is high only when that cycle selected a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 10 | Host address |
| host_rd | input | 1 | Read strobe, active high |
| host_wr | input | 1 | Write strobe, active high |
| space_attr | input | 1 | 1 = attribute memory, 0 = I/O space |
| com_sel | input | 2 | I/O base choice code |
| host_wdata | input | 8 | Host write data |
| cis_sel | output | 1 | Information structure area selected |
| cis_index | output | 8 | Word index within that area |
| cfg_sel | output | 8 | One-hot configuration register select |
| uart_sel | output | 12 | One-hot UART register select |
| sel_rd | output | 1 | Qualified read enable |
| sel_wr | output | 1 | Qualified write enable |
| wr_keep | output | 8 | Per-bit write enable mask |
| dlab | output | 1 | Divisor latch access bit copy |

## Verification
The bench builds the block with its default sizes: 256 information structure words, 8 configuration registers and 10 address bits. These values put the area edges at word indices 255, 256, 263 and 264, and the bench hits each of them. It uses all four base codes, with addresses just inside and just outside each window. It drives every offset in both directions with the access bit both clear and set, and it writes offset 3 in the same cycle as the effect is looked for. A free-running pseudo-random phase then mixes both spaces, both strobes and all base codes.

// File: rtl/pcdec_pkg.sv
package pcdec_pkg;
  localparam int UREG_N = 12;

  typedef enum logic [3:0] {
    U_RBR = 4'd0, U_THR = 4'd1, U_DLL = 4'd2, U_DLM = 4'd3,
    U_IER = 4'd4, U_IIR = 4'd5, U_FCR = 4'd6, U_LCR = 4'd7,
    U_MCR = 4'd8, U_LSR = 4'd9, U_MSR = 4'd10, U_SCR = 4'd11
  } ureg_e;

  localparam logic [15:0] BASE_A = 16'h03F8;
  localparam logic [15:0] BASE_B = 16'h02F8;
  localparam logic [15:0] BASE_C = 16'h03E8;
  localparam logic [15:0] BASE_D = 16'h02E8;
endpackage

// File: rtl/pcdec_attr.sv
module pcdec_attr #(
  parameter int ADDR_W = 10,
  parameter int CIS_N  = 256,
  parameter int CFG_N  = 8,
  localparam int IDX_W = ADDR_W - 1,
  localparam int CIS_W = $clog2(CIS_N)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  output logic              cis_hit,
  output logic [CIS_W-1:0]  cis_idx,
  output logic [CFG_N-1:0]  cfg_hit
);
  logic [IDX_W-1:0] widx;
  logic             even_ok;

  assign widx    = addr[ADDR_W-1:1];
  assign even_ok = en && !addr[0];
  assign cis_hit = even_ok && (widx < IDX_W'(CIS_N));
  assign cis_idx = cis_hit ? widx[CIS_W-1:0] : '0;

  for (genvar g = 0; g < CFG_N; g++) begin : g_cfg
    assign cfg_hit[g] = even_ok && (widx == IDX_W'(CIS_N + g));
  end
endmodule

// File: rtl/pcdec_io.sv
module pcdec_io
  import pcdec_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        com_code,
  input  logic              en,
  input  logic              is_rd,
  input  logic              dlab,
  output logic              hit,
  output logic [2:0]        off,
  output logic [UREG_N-1:0] ureg_hit
);
  logic [ADDR_W-1:0] base;
  ureg_e             which;

  always_comb begin
    case (com_code)
      2'd0:    base = ADDR_W'(BASE_A);
      2'd1:    base = ADDR_W'(BASE_B);
      2'd2:    base = ADDR_W'(BASE_C);
      default: base = ADDR_W'(BASE_D);
    endcase
  end

  assign hit = en && ({addr[ADDR_W-1:3], 3'b000} == base);
  assign off = addr[2:0];

  always_comb begin
    case (off)
      3'd0:    which = dlab ? U_DLL : (is_rd ? U_RBR : U_THR);
      3'd1:    which = dlab ? U_DLM : U_IER;
      3'd2:    which = is_rd ? U_IIR : U_FCR;
      3'd3:    which = U_LCR;
      3'd4:    which = U_MCR;
      3'd5:    which = U_LSR;
      3'd6:    which = U_MSR;
      default: which = U_SCR;
    endcase
  end

  always_comb begin
    ureg_hit = '0;
    if (hit) ureg_hit[which] = 1'b1;
  end
endmodule

// File: rtl/pcdec_dlab.sv
module pcdec_dlab #(
  parameter int DATA_W   = 8,
  parameter int DLAB_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  output logic              dlab
);
  always_ff @(posedge clk) begin
    if (rst)       dlab <= 1'b0;
    else if (load) dlab <= wdata[DLAB_BIT];
  end
endmodule

// File: rtl/pccard_reg_decode.sv
module pccard_reg_decode
  import pcdec_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int CIS_N      = 256,
  parameter int CFG_N      = 8,
  parameter int DLAB_BIT   = 7,
  parameter int MCR_RO_BIT = 5,
  localparam int CIS_W     = $clog2(CIS_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              space_attr,
  input  logic [1:0]        com_sel,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              cis_sel,
  output logic [CIS_W-1:0]  cis_index,
  output logic [CFG_N-1:0]  cfg_sel,
  output logic [UREG_N-1:0] uart_sel,
  output logic              sel_rd,
  output logic              sel_wr,
  output logic [DATA_W-1:0] wr_keep,
  output logic              dlab
);
  localparam logic [DATA_W-1:0] KEEP_ALL = '1;
  localparam logic [DATA_W-1:0] KEEP_MCR = ~(DATA_W'(1) << MCR_RO_BIT);

  logic              rd_c, wr_c, acc_c;
  logic              a_cis;
  logic [CIS_W-1:0]  a_idx;
  logic [CFG_N-1:0]  a_cfg;
  logic              io_hit;
  logic [2:0]        io_off;
  logic [UREG_N-1:0] io_reg;
  logic              any_hit;
  logic              dlab_load;

  assign rd_c  = host_rd && !host_wr;
  assign wr_c  = host_wr && !host_rd;
  assign acc_c = rd_c || wr_c;

  pcdec_attr #(.ADDR_W(ADDR_W), .CIS_N(CIS_N), .CFG_N(CFG_N)) u_attr (
    .addr    (host_addr),
    .en      (acc_c && space_attr),
    .cis_hit (a_cis),
    .cis_idx (a_idx),
    .cfg_hit (a_cfg)
  );

  pcdec_io #(.ADDR_W(ADDR_W)) u_io (
    .addr     (host_addr),
    .com_code (com_sel),
    .en       (acc_c && !space_attr),
    .is_rd    (rd_c),
    .dlab     (dlab),
    .hit      (io_hit),
    .off      (io_off),
    .ureg_hit (io_reg)
  );

  assign dlab_load = wr_c && io_hit && (io_off == 3'd3);

  pcdec_dlab #(.DATA_W(DATA_W), .DLAB_BIT(DLAB_BIT)) u_dlab (
    .clk   (clk),
    .rst   (rst),
    .load  (dlab_load),
    .wdata (host_wdata),
    .dlab  (dlab)
  );

  assign any_hit = a_cis || (|a_cfg) || io_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cis_sel   <= 1'b0;
      cis_index <= '0;
      cfg_sel   <= '0;
      uart_sel  <= '0;
      sel_rd    <= 1'b0;
      sel_wr    <= 1'b0;
      wr_keep   <= KEEP_ALL;
    end else begin
      cis_sel   <= a_cis;
      cis_index <= a_idx;
      cfg_sel   <= a_cfg;
      uart_sel  <= io_reg;
      sel_rd    <= rd_c && any_hit;
      sel_wr    <= wr_c && any_hit;
      wr_keep   <= (wr_c && io_reg[U_MCR]) ? KEEP_MCR : KEEP_ALL;
    end
  end
endmodule

// File: rtl/pcdec_chk.sv
module pcdec_chk
  import pcdec_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int CFG_N  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_rd,
  input logic              host_wr,
  input logic              space_attr,
  input logic              cis_sel,
  input logic [CFG_N-1:0]  cfg_sel,
  input logic [UREG_N-1:0] uart_sel,
  input logic              sel_rd,
  input logic              sel_wr,
  input logic [DATA_W-1:0] wr_keep,
  input logic              dlab
);
  p_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cis_sel, cfg_sel, uart_sel}));

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (host_rd == host_wr) |=> (!cis_sel && cfg_sel == '0 && uart_sel == '0 && !sel_rd && !sel_wr));

  p_dir_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(sel_rd && sel_wr));

  p_dlab_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !host_wr |=> $stable(dlab));

  p_odd_attr_r2: assert property (@(posedge clk) disable iff (rst)
    (space_attr && host_addr[0]) |=> (!cis_sel && cfg_sel == '0 && uart_sel == '0));

  p_keep_r9: assert property (@(posedge clk) disable iff (rst)
    !(uart_sel[U_MCR] && sel_wr) |-> (wr_keep == '1));

  p_rd_only_r4: assert property (@(posedge clk) disable iff (rst)
    sel_wr |-> (!uart_sel[U_RBR] && !uart_sel[U_IIR]));

  p_wr_only_r6: assert property (@(posedge clk) disable iff (rst)
    sel_rd |-> (!uart_sel[U_THR] && !uart_sel[U_FCR]));
endmodule

bind pccard_reg_decode pcdec_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_N(CFG_N)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_addr  (host_addr),
  .host_rd    (host_rd),
  .host_wr    (host_wr),
  .space_attr (space_attr),
  .cis_sel    (cis_sel),
  .cfg_sel    (cfg_sel),
  .uart_sel   (uart_sel),
  .sel_rd     (sel_rd),
  .sel_wr     (sel_wr),
  .wr_keep    (wr_keep),
  .dlab       (dlab)
);

// File: tb/tb_pccard_reg_decode.sv
`timescale 1ns/1ps
module tb_pccard_reg_decode;
  logic        clk = 1'b0;
  logic        rst;
  logic [9:0]  host_addr;
  logic        host_rd, host_wr, space_attr;
  logic [1:0]  com_sel;
  logic [7:0]  host_wdata;
  logic        cis_sel;
  logic [7:0]  cis_index;
  logic [7:0]  cfg_sel;
  logic [11:0] uart_sel;
  logic        sel_rd, sel_wr;
  logic [7:0]  wr_keep;
  logic        dlab;

  int checks = 0;
  int errors = 0;

  logic        m_dlab;
  logic        e_cis;
  logic [7:0]  e_idx;
  logic [7:0]  e_cfg;
  logic [11:0] e_u;
  logic        e_rd, e_wr;
  logic [7:0]  e_keep;
  string       u_tag;

  always #10 clk = ~clk;

  pccard_reg_decode dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .space_attr(space_attr), .com_sel(com_sel),
    .host_wdata(host_wdata), .cis_sel(cis_sel), .cis_index(cis_index),
    .cfg_sel(cfg_sel), .uart_sel(uart_sel), .sel_rd(sel_rd), .sel_wr(sel_wr),
    .wr_keep(wr_keep), .dlab(dlab)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 cis_sel", 32'(cis_sel), 32'(e_cis));
    chk("R2 cis_index", 32'(cis_index), 32'(e_idx));
    chk("R2 cfg_sel", 32'(cfg_sel), 32'(e_cfg));
    chk(u_tag, 32'(uart_sel), 32'(e_u));
    chk("R11 sel_rd", 32'(sel_rd), 32'(e_rd));
    chk("R11 sel_wr", 32'(sel_wr), 32'(e_wr));
    chk("R9 wr_keep", 32'(wr_keep), 32'(e_keep));
    chk("R8 dlab", 32'(dlab), 32'(m_dlab));
    chk("R10 one select", 32'($countones({cis_sel, cfg_sel, uart_sel}) <= 1), 32'd1);
  endtask

  // Reference: decode of the cycle applied now appears after the next edge (R11)
  task automatic step(input logic rd, input logic wr, input logic attr,
                      input logic [1:0] com, input logic [9:0] a, input logic [7:0] d);
    logic r, w, hit, nd;
    int wi, off, u, base;
    host_rd = rd; host_wr = wr; space_attr = attr;
    com_sel = com; host_addr = a; host_wdata = d;
    r = rd && !wr; w = wr && !rd; hit = 1'b0; nd = m_dlab;
    e_cis = 0; e_idx = 0; e_cfg = 0; e_u = 0; e_keep = 8'hFF;
    u_tag = "R3 uart_sel";
    if (r || w) begin
      if (attr) begin
        if (a[0] == 1'b0) begin
          wi = int'(a) / 2;
          if (wi < 256) begin e_cis = 1; e_idx = 8'(wi); hit = 1; end
          else if (wi < 264) begin e_cfg[wi-256] = 1'b1; hit = 1; end
        end
      end else begin
        case (com)
          2'd0: base = 'h3F8;
          2'd1: base = 'h2F8;
          2'd2: base = 'h3E8;
          default: base = 'h2E8;
        endcase
        if ((int'(a) / 8) * 8 == base) begin
          hit = 1; off = int'(a) % 8;
          case (off)
            0: begin u = m_dlab ? 2 : (r ? 0 : 1); u_tag = m_dlab ? "R5 uart_sel" : "R4 uart_sel"; end
            1: begin u = m_dlab ? 3 : 4; u_tag = "R5 uart_sel"; end
            2: begin u = r ? 5 : 6; u_tag = "R6 uart_sel"; end
            3: begin u = 7; u_tag = "R6 uart_sel"; end
            default: begin u = off + 4; u_tag = "R7 uart_sel"; end
          endcase
          e_u[u] = 1'b1;
          if (w && u == 8) e_keep = 8'hDF;
          if (w && off == 3) nd = d[7];
        end
      end
    end
    e_rd = r && hit; e_wr = w && hit;
    @(posedge clk);
    m_dlab = nd;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    rst = 1; host_rd = 0; host_wr = 0; space_attr = 0; com_sel = 0;
    host_addr = 0; host_wdata = 0; m_dlab = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 selects", 32'({cis_sel, cfg_sel, uart_sel, sel_rd, sel_wr}), 32'd0);
    chk("R1 wr_keep", 32'(wr_keep), 32'hFF);
    chk("R1 dlab", 32'(dlab), 32'd0);
    rst = 0;
    // R10 idle and both strobes
    step(0, 0, 0, 0, 10'h3F8, 8'h80);
    step(1, 1, 0, 0, 10'h3FB, 8'h80);
    step(1, 1, 1, 0, 10'h000, 8'h00);
    // R2 attribute area edges and odd addresses
    step(1, 0, 1, 0, 10'h000, 0);
    step(1, 0, 1, 0, 10'd510, 0);
    step(0, 1, 1, 0, 10'd511, 0);
    step(1, 0, 1, 0, 10'd3, 0);
    for (int k = 256; k < 264; k++) step(k % 2 == 0, k % 2 != 0, 1, 0, 10'(k * 2), 0);
    step(0, 1, 1, 0, 10'(264 * 2), 0);
    step(1, 0, 1, 0, 10'(266 * 2), 0);
    // R3 every base, inside and outside
    for (int c = 0; c < 4; c++) begin
      for (int o = 0; o < 8; o++) begin
        step(1, 0, 0, 2'(c), 10'h3F8 - 10'(c[0]) * 10'h100 - 10'(c[1]) * 10'h10 + 10'(o), 0);
        step(0, 1, 0, 2'(c), 10'h3F8 - 10'(c[0]) * 10'h100 - 10'(c[1]) * 10'h10 + 10'(o), 8'h20);
      end
      step(1, 0, 0, 2'(c), 10'h3F0 - 10'(c[0]) * 10'h100 - 10'(c[1]) * 10'h10, 0);
    end
    step(1, 0, 0, 2'd1, 10'h3F8, 0);
    // R8 set access bit; same-cycle access uses old value
    step(0, 1, 0, 0, 10'h3FB, 8'h83);
    step(1, 0, 0, 0, 10'h3F8, 0);
    step(0, 1, 0, 0, 10'h3F8, 0);
    step(0, 1, 0, 0, 10'h3F9, 0);
    step(1, 0, 0, 0, 10'h3FB, 8'h00);
    step(0, 1, 0, 0, 10'h3FC, 8'hFF);
    step(0, 1, 1, 0, 10'h3FB, 8'h00);
    step(0, 1, 0, 0, 10'h3FB, 8'h03);
    step(0, 1, 0, 0, 10'h3F9, 0);
    step(1, 0, 0, 0, 10'h3F8, 0);
    // mixed pseudo-random traffic
    lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0], lf[1], lf[2] & lf[3], lf[5:4],
           lf[6] ? {2'b11, lf[8], 4'b1110, lf[15:13]} : lf[15:6], {lf[9], lf[12:6]});
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule